// File: doc/BRIEF.md
# Serial peripheral master with hardware chip-select sequencing

This block is a master for the four-wire serial peripheral bus. Software pushes frames into a small transmit queue over a valid/ready port. The block shifts each frame out on MOSI and samples MISO at the same time. Every received frame goes into a receive queue, which software drains through a second valid/ready port. The bus runs with the clock idling low: MOSI changes on the falling SCLK edge and MISO is sampled on the rising edge. A half SCLK period lasts `cfg_div_i + 1` system clocks.

The block drives chip select itself and never needs software for it. Before the first SCLK edge it waits a programmed setup time, after the last edge a hold time, and between frames in a burst an idle gap. Each of the three is set from 0 to 7 SCLK periods. Static configuration inputs set the active level of chip select, the bit order, and independent inversion of the outgoing and incoming data lines.

In the auto-transmit mode the block starts a frame whenever the receive queue has room. When the transmit queue is empty at frame start, it sends a programmed default word and pulses an underflow flag. This lets a system read a slave continuously without refilling the transmit queue. Configuration must be held stable while `busy_o` is high.

Top module: `spi_autocs_master`

## Requirements
- R1: After reset, chip select is at its inactive level, `sclk_o` is low, `busy_o` and `underflow_o` are low, `rx_valid_o` is low and `tx_ready_o` is high.
- R2: With `cfg_cs_high_i` = 1, chip select is high during a transfer and low at idle; with `cfg_cs_high_i` = 0, the levels are the reverse.
- R3: The first rising SCLK edge of a burst comes (2·S+1)·H system clocks after chip select turns active, where S = `cfg_setup_i` and H = `cfg_div_i` + 1.
- R4: When no frame follows, chip select turns inactive 1 + 2·D·H clocks after the last falling SCLK edge, where D = `cfg_hold_i`.
- R5: When a further frame can start, chip select stays active and the next first rising edge comes 1 + (2·G+1)·H clocks after the previous last falling edge, where G = `cfg_gap_i`.
- R6: With `cfg_lsb_first_i` = 0, bit 7 of a frame goes on the wire first and the first received bit lands in bit 7 of the received frame. With `cfg_lsb_first_i` = 1, bit 0 is first in both directions.
- R7: `cfg_inv_mosi_i` inverts every outgoing bit and `cfg_inv_miso_i` inverts every sampled bit, each independently of the other.
- R8: Each frame is 8 bits. MISO is sampled on each rising SCLK edge, and the complete frame is written to the receive queue after the eighth falling edge.
- R9: A frame starts only when the receive queue is not full. Outside auto-transmit mode, a frame also needs a non-empty transmit queue, and chip select stays inactive otherwise. A stalled frame starts once software pops the receive queue.
- R10: In auto-transmit mode, a frame that starts with the transmit queue empty sends `cfg_dflt_word_i` and raises `underflow_o` for exactly one clock.
- R11: In auto-transmit mode, frames keep running until the receive queue is full and then stop, so an empty queue of depth 4 receives exactly 4 frames.
- R12: SCLK is low whenever no bit is being shifted, and MOSI never changes while SCLK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_div_i | input | DIV_W | Half SCLK period minus one, in system clocks |
| cfg_setup_i | input | 3 | Chip-select setup, SCLK periods |
| cfg_hold_i | input | 3 | Chip-select hold, SCLK periods |
| cfg_gap_i | input | 3 | Gap between frames, SCLK periods |
| cfg_cs_high_i | input | 1 | 1: chip select active high |
| cfg_lsb_first_i | input | 1 | 1: least significant bit first |
| cfg_inv_mosi_i | input | 1 | Invert outgoing data |
| cfg_inv_miso_i | input | 1 | Invert incoming data |
| cfg_auto_tx_i | input | 1 | Auto-transmit mode |
| cfg_dflt_word_i | input | FRAME_W | Word sent on transmit underflow |
| tx_valid_i | input | 1 | Transmit push valid |
| tx_data_i | input | FRAME_W | Transmit push data |
| tx_ready_o | output | 1 | Transmit queue has room |
| rx_valid_o | output | 1 | Receive queue holds a frame |
| rx_data_o | output | FRAME_W | Oldest received frame |
| rx_ready_i | input | 1 | Receive pop |
| busy_o | output | 1 | Sequencer not idle |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_full_o | output | 1 | Receive queue full |
| underflow_o | output | 1 | One-clock pulse on default-word frame |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |

## Verification
A phase counter or sequencer state that is wrong shows up at once as a shifted edge on the pins. The distance from chip select to the first rising edge, from the last falling edge to the next rising edge, or from the last falling edge to chip-select release differs from the formula by whole half periods. The bench measures these distances in clocks within the burst where the fault occurs. A wrong shift direction or inversion corrupts the first frame on the wire and in the receive queue. A wrong start condition gives the wrong number of frames in a burst or an underflow count off by one. Both appear within a few frames of the fault.

// File: rtl/spi_am_pkg.sv
package spi_am_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_NEXT,
    ST_HOLD,
    ST_GAP
  } seq_state_e;

  localparam int unsigned TIME_W = 3;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wr_q, rd_q;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign data_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q[AW-1:0]] <= push_data_i;
  end

  assert_no_push_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_pop_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(en_i) || (div_i == '0));
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_am_pkg::*;
#(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [TIME_W-1:0]  cfg_setup_i,
  input  logic [TIME_W-1:0]  cfg_hold_i,
  input  logic [TIME_W-1:0]  cfg_gap_i,
  input  logic               cfg_lsb_first_i,
  input  logic               cfg_inv_mosi_i,
  input  logic               cfg_inv_miso_i,
  input  logic               cfg_auto_i,
  input  logic [FRAME_W-1:0] dflt_i,
  input  logic               tx_empty_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               rx_full_i,
  input  logic               miso_i,
  output logic               tx_pop_o,
  output logic               rx_push_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               baud_en_o,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               cs_act_o,
  output logic               busy_o,
  output logic               underflow_o
);
  localparam int unsigned BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  seq_state_e         state_q;
  logic [TIME_W:0]    ph_q;
  logic [BW-1:0]      bit_q;
  logic [FRAME_W-1:0] tx_sh_q, rx_sh_q;
  logic               sclk_q, uf_q;
  logic               can_go, at_start, last_fall, in_bit;

  assign can_go    = !rx_full_i && (!tx_empty_i || cfg_auto_i);
  assign at_start  = (state_q == ST_IDLE) || (state_q == ST_NEXT);
  assign tx_pop_o  = at_start && can_go && !tx_empty_i;
  assign last_fall = (state_q == ST_XFER) && tick_i && sclk_q && (bit_q == LAST_BIT);
  assign rx_push_o = last_fall;
  assign rx_data_o = rx_sh_q;
  assign baud_en_o = (state_q == ST_SETUP) || (state_q == ST_XFER) ||
                     (state_q == ST_HOLD)  || (state_q == ST_GAP);
  assign in_bit    = miso_i ^ cfg_inv_miso_i;
  assign mosi_o    = (cfg_lsb_first_i ? tx_sh_q[0] : tx_sh_q[FRAME_W-1]) ^ cfg_inv_mosi_i;
  assign sclk_o    = sclk_q;
  assign cs_act_o  = (state_q != ST_IDLE);
  assign busy_o    = (state_q != ST_IDLE);
  assign underflow_o = uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      sclk_q  <= 1'b0;
      uf_q    <= 1'b0;
    end else begin
      uf_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_NEXT: begin
          if (can_go) begin
            tx_sh_q <= tx_empty_i ? dflt_i : tx_data_i;
            uf_q    <= tx_empty_i;
            bit_q   <= '0;
            sclk_q  <= 1'b0;
            if (state_q == ST_IDLE && cfg_setup_i != '0) begin
              state_q <= ST_SETUP;
              ph_q    <= {cfg_setup_i, 1'b0};
            end else if (state_q == ST_NEXT && cfg_gap_i != '0) begin
              state_q <= ST_GAP;
              ph_q    <= {cfg_gap_i, 1'b0};
            end else begin
              state_q <= ST_XFER;
            end
          end else if (state_q == ST_NEXT) begin
            if (cfg_hold_i != '0) begin
              state_q <= ST_HOLD;
              ph_q    <= {cfg_hold_i, 1'b0};
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_SETUP, ST_GAP, ST_HOLD: begin
          if (tick_i) begin
            if (ph_q == 1) state_q <= (state_q == ST_HOLD) ? ST_IDLE : ST_XFER;
            else           ph_q    <= ph_q - 1'b1;
          end
        end
        ST_XFER: begin
          if (tick_i) begin
            if (!sclk_q) begin
              sclk_q  <= 1'b1;
              rx_sh_q <= cfg_lsb_first_i ? {in_bit, rx_sh_q[FRAME_W-1:1]}
                                         : {rx_sh_q[FRAME_W-2:0], in_bit};
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == LAST_BIT) begin
                state_q <= ST_NEXT;
              end else begin
                bit_q   <= bit_q + 1'b1;
                tx_sh_q <= cfg_lsb_first_i ? (tx_sh_q >> 1) : (tx_sh_q << 1);
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_sclk_low_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_XFER) |-> !sclk_q);
  assert_edge_inside_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> cs_act_o);
  assert_mosi_stable_high_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && $past(sclk_q)) |-> $stable(tx_sh_q));
  assert_underflow_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q |-> $past(cfg_auto_i && tx_empty_i));
  assert_next_after_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NEXT) |-> $past(state_q == ST_XFER));
endmodule

// File: rtl/spi_autocs_master.sv
module spi_autocs_master
  import spi_am_pkg::*;
#(
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned FIFO_D  = 4,
  parameter int unsigned DIV_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   cfg_div_i,
  input  logic [2:0]         cfg_setup_i,
  input  logic [2:0]         cfg_hold_i,
  input  logic [2:0]         cfg_gap_i,
  input  logic               cfg_cs_high_i,
  input  logic               cfg_lsb_first_i,
  input  logic               cfg_inv_mosi_i,
  input  logic               cfg_inv_miso_i,
  input  logic               cfg_auto_tx_i,
  input  logic [FRAME_W-1:0] cfg_dflt_word_i,
  input  logic               tx_valid_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  output logic               tx_ready_o,
  output logic               rx_valid_o,
  output logic [FRAME_W-1:0] rx_data_o,
  input  logic               rx_ready_i,
  output logic               busy_o,
  output logic               tx_empty_o,
  output logic               rx_full_o,
  output logic               underflow_o,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               cs_o
);
  logic               tx_full, tx_pop, rx_empty, rx_push, tick, baud_en, cs_act;
  logic [FRAME_W-1:0] tx_head, rx_word;

  assign tx_ready_o = !tx_full;
  assign rx_valid_o = !rx_empty;
  assign cs_o       = cfg_cs_high_i ? cs_act : !cs_act;

  spi_sync_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_D)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_valid_i && !tx_full), .push_data_i(tx_data_i),
    .pop_i(tx_pop), .data_o(tx_head), .full_o(tx_full), .empty_o(tx_empty_o)
  );

  spi_sync_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_D)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .push_data_i(rx_word),
    .pop_i(rx_ready_i && !rx_empty), .data_o(rx_data_o),
    .full_o(rx_full_o), .empty_o(rx_empty)
  );

  spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .en_i(baud_en), .div_i(cfg_div_i), .tick_o(tick)
  );

  spi_frame_seq #(.FRAME_W(FRAME_W)) u_seq (
    .clk_i, .rst_ni, .tick_i(tick),
    .cfg_setup_i, .cfg_hold_i, .cfg_gap_i,
    .cfg_lsb_first_i, .cfg_inv_mosi_i, .cfg_inv_miso_i,
    .cfg_auto_i(cfg_auto_tx_i), .dflt_i(cfg_dflt_word_i),
    .tx_empty_i(tx_empty_o), .tx_data_i(tx_head), .rx_full_i(rx_full_o),
    .miso_i, .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_word),
    .baud_en_o(baud_en), .sclk_o, .mosi_o, .cs_act_o(cs_act), .busy_o,
    .underflow_o
  );

  assert_cs_idle_level_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_o == !cfg_cs_high_i));
endmodule

// File: tb/tb_spi_autocs_master.sv
module tb_spi_autocs_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] div = '0;
  logic [2:0] setup = '0, hold = '0, gap = '0;
  logic cs_high = 0, lsb = 0, inv_o = 0, inv_i = 0, auto_tx = 0;
  logic [7:0] dflt = '0, tx_data = '0, rx_data;
  logic tx_valid = 0, rx_ready = 0;
  logic tx_ready, rx_valid, busy, tx_empty, rx_full, uf, sclk, mosi, miso, cs;

  spi_autocs_master dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_div_i(div), .cfg_setup_i(setup),
    .cfg_hold_i(hold), .cfg_gap_i(gap), .cfg_cs_high_i(cs_high),
    .cfg_lsb_first_i(lsb), .cfg_inv_mosi_i(inv_o), .cfg_inv_miso_i(inv_i),
    .cfg_auto_tx_i(auto_tx), .cfg_dflt_word_i(dflt), .tx_valid_i(tx_valid),
    .tx_data_i(tx_data), .tx_ready_o(tx_ready), .rx_valid_o(rx_valid),
    .rx_data_o(rx_data), .rx_ready_i(rx_ready), .busy_o(busy),
    .tx_empty_o(tx_empty), .rx_full_o(rx_full), .underflow_o(uf),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_o(cs)
  );

  // slave model: wire order word, MSB of slv_word leaves first
  logic [7:0] slv_word = '0, cap = '0;
  logic [2:0] slv_idx = '0;
  assign miso = slv_word[3'd7 - slv_idx];
  always @(negedge sclk) slv_idx <= slv_idx + 3'd1;
  always @(posedge sclk) cap <= {cap[6:0], mosi};

  // pin monitor, time in clocks
  int cyc = 0, n_rise = 0, n_fall = 0, n_cson = 0, n_uf = 0, mosi_bad = 0;
  int cs_on_t = 0, cs_off_t = 0;
  int rise_t [64];
  int fall_t [64];
  logic log_clr = 1'b1, p_act = 1'b0, p_sclk = 1'b0, p_mosi = 1'b0, act;
  always @(negedge clk) begin
    cyc = cyc + 1;
    act = cs_high ? cs : !cs;
    if (log_clr) begin
      n_rise = 0; n_fall = 0; n_cson = 0; n_uf = 0; mosi_bad = 0;
    end else begin
      if (act && !p_act) begin cs_on_t = cyc; n_cson = n_cson + 1; end
      if (!act && p_act) cs_off_t = cyc;
      if (sclk && !p_sclk) begin if (n_rise < 64) rise_t[n_rise] = cyc; n_rise = n_rise + 1; end
      if (!sclk && p_sclk) begin if (n_fall < 64) fall_t[n_fall] = cyc; n_fall = n_fall + 1; end
      if (uf) n_uf = n_uf + 1;
      if (sclk && p_sclk && mosi != p_mosi) mosi_bad = mosi_bad + 1;
    end
    p_act = act; p_sclk = sclk; p_mosi = mosi;
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); tx_valid = 1; tx_data = d;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic pop();
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  task automatic quiet();
    int q = 0;
    while (q < 8) begin
      @(negedge clk);
      if (busy) q = 0; else q++;
    end
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1;
    @(negedge clk); log_clr = 0;
  endtask

  // {lsb, inv_mosi, inv_miso, tx, slave wire word, expected wire out, expected rx}
  localparam logic [34:0] VECS [6] = '{
    {3'b000, 8'hA5, 8'h3C, 8'hA5, 8'h3C},
    {3'b100, 8'h01, 8'h80, 8'h80, 8'h01},
    {3'b010, 8'hF0, 8'h0F, 8'h0F, 8'h0F},
    {3'b001, 8'h12, 8'h55, 8'h12, 8'hAA},
    {3'b111, 8'h1E, 8'hC3, 8'h87, 8'h3C},
    {3'b100, 8'hB4, 8'h0D, 8'h2D, 8'hB0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs", cs, 1); chk("R1 sclk", sclk, 0); chk("R1 busy", busy, 0);
    chk("R1 rx_valid", rx_valid, 0); chk("R1 tx_ready", tx_ready, 1);
    chk("R1 underflow", uf, 0);
    clear_log();

    // R6 R7 R8: vector table, zero timing
    for (int i = 0; i < 6; i++) begin
      {lsb, inv_o, inv_i} = VECS[i][34:32];
      slv_word = VECS[i][23:16];
      push(VECS[i][31:24]);
      quiet();
      chk($sformatf("R6/R7 wire out vec%0d", i), cap, VECS[i][15:8]);
      chk($sformatf("R8/R7 rx vec%0d", i), rx_data, VECS[i][7:0]);
      chk($sformatf("R8 rx_valid vec%0d", i), rx_valid, 1);
      pop();
    end
    lsb = 0; inv_o = 0; inv_i = 0;
    chk("R12 mosi stable while sclk high", mosi_bad, 0);

    // R3 R4 R5 timing, H=3
    div = 8'd2; setup = 3'd2; hold = 3'd3; gap = 3'd1;
    clear_log();
    @(negedge clk); tx_valid = 1; tx_data = 8'h11;
    @(negedge clk); tx_data = 8'h22;
    @(negedge clk); tx_valid = 0;
    quiet();
    chk("R3 setup clocks", rise_t[0] - cs_on_t, 15);
    chk("R5 gap clocks", rise_t[8] - fall_t[7], 10);
    chk("R5 cs held over burst", n_cson, 1);
    chk("R4 hold clocks", cs_off_t - fall_t[15], 19);
    chk("R8 edge count", n_rise, 16);
    pop(); pop();

    // R3 R4 R5 zero settings, H=1
    div = 8'd0; setup = 0; hold = 0; gap = 0;
    clear_log();
    @(negedge clk); tx_valid = 1; tx_data = 8'h33;
    @(negedge clk); tx_data = 8'h44;
    @(negedge clk); tx_valid = 0;
    quiet();
    chk("R3 zero setup", rise_t[0] - cs_on_t, 1);
    chk("R5 zero gap", rise_t[8] - fall_t[7], 2);
    chk("R4 zero hold", cs_off_t - fall_t[15], 1);
    pop(); pop();

    // R2 active-high polarity
    cs_high = 1;
    @(negedge clk);
    chk("R2 idle level high-active", cs, 0);
    div = 8'd3;
    push(8'h5A);
    @(negedge clk);
    chk("R2 active level high-active", cs, 1);
    quiet();
    chk("R2 back to idle", cs, 0);
    pop();
    cs_high = 0; div = 8'd0;

    // R9 stall on full receive queue
    clear_log();
    for (int k = 0; k < 4; k++) push(8'(k));
    quiet();
    chk("R9 rx full after 4", rx_full, 1);
    push(8'hEE);
    repeat (40) @(negedge clk);
    chk("R9 no frame while rx full", n_cson == 1 ? n_rise : 99, 32);
    chk("R9 cs inactive while stalled", cs, 1);
    chk("R9 tx item kept", tx_empty, 0);
    pop();
    quiet();
    chk("R9 resumed after pop", n_rise, 40);
    chk("R9 tx drained", tx_empty, 1);
    for (int k = 0; k < 4; k++) pop();
    repeat (20) @(negedge clk);
    chk("R9 idle on empty tx", busy, 0);
    chk("R10 no underflow outside auto", n_uf, 0);

    // R10 R11 auto-transmit
    slv_word = 8'h00; dflt = 8'h5A;
    clear_log();
    @(negedge clk); auto_tx = 1;
    quiet();
    chk("R11 frames until full", n_rise, 32);
    chk("R11 rx full", rx_full, 1);
    chk("R10 underflow pulses", n_uf, 4);
    chk("R10 default word on wire", cap, 8'h5A);
    auto_tx = 0;
    for (int k = 0; k < 4; k++) begin
      chk("R8 auto rx data", rx_data, 8'h00);
      pop();
    end
    chk("R12 mosi stable overall", mosi_bad, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule